// File: doc/BRIEF.md
# Halfword Instruction Prefetch Buffer

This block sits between an instruction bus and a decoder. It fetches aligned 32-bit words and passes whole instructions to the decoder. An instruction is either 16 or 32 bits long and may start on any halfword boundary. A 32-bit instruction that starts in the upper half of a word takes its second half from the next word, and the block joins the two halves before it offers the instruction.

The block keeps a small queue of halfwords, with room for three words, and issues one word request per bus access. The bus accepts a request in the cycle it is raised and returns the data later, in request order, with a valid strobe.

A branch or flush input supplies a new halfword-aligned target. The flush clears the queue, drops every bus response that was still due from before the flush, and restarts fetching at the word that holds the target. The decoder sees one instruction at a time, with its size and address, and takes it by raising ready.

Top module: `hw_prefetch_buf`

## Requirements
- R1: In the first cycle after reset no instruction is offered, and a fetch is requested for the word at the boot address (default 0).
- R2: Every fetch address is word aligned (bits [1:0] zero). Successive requests without an intervening flush step up by 4.
- R3: The words held plus the words still due from live requests never exceed three. With no bus response, exactly three requests are issued and then fetching stops.
- R4: An offered instruction is 32 bits long when bits [15:11] of its first halfword are 0b11101, 0b11110 or 0b11111, and 16 bits long otherwise. Halfwords are taken from a word in little-endian order: bits [15:0] first, then bits [31:16].
- R5: A 16-bit instruction is offered as {16'h0000, halfword} on instData.
- R6: A 32-bit instruction is offered with its first halfword in instData[31:16] and its second halfword in [15:0], including when the two halves come from consecutive words.
- R7: instAddr is halfword aligned. Each accepted instruction advances it by 2 for a 16-bit instruction or by 4 for a 32-bit instruction.
- R8: While an offered instruction is not taken and no flush occurs, it stays offered with unchanged data, size and address.
- R9: In a flush cycle no instruction is offered and no fetch is requested. In the next cycle the queue is empty, and the next request is for the word that holds the target.
- R10: A bus response belonging to a request issued before a flush, including one that arrives in the flush cycle, never reaches the decoder.
- R11: When the target has bit 1 set, the lower halfword of the first fetched word is skipped, and the first instruction offered is at the target address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchReq | output | 1 | Word fetch request, accepted in the cycle it is high |
| fetchAddr | output | ADDR_W | Word-aligned fetch address |
| fetchValid | input | 1 | Read data returned for the oldest outstanding request |
| fetchData | input | 32 | Returned word |
| flushIn | input | 1 | Branch/flush strobe |
| flushAddr | input | ADDR_W | Halfword-aligned branch target |
| instValid | output | 1 | Instruction offered to the decoder |
| instIs32 | output | 1 | Offered instruction is 32 bits long |
| instData | output | 32 | Offered instruction (format per R5/R6) |
| instAddr | output | ADDR_W | Address of the offered instruction |
| instReady | input | 1 | Decoder takes the offered instruction |

## Verification
The hardest case to reach from the ports is a flush that lands while responses from the old stream are still in flight. The block must drop those responses and keep the new ones, which arrive after them in the same order. The bench keeps its bus model's queue of pending requests across every flush and returns the stale words at their normal latency. It sweeps latency, gaps in the response stream, decoder-ready patterns and target offsets, so flushes fall with zero to three requests outstanding and with 32-bit instructions straddling a word boundary in either half.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  // Strobes from the control side to the halfword datapath.
  typedef struct packed {
    logic flush;         // clear queue, load new head address
    logic push;          // accept the returned word this cycle
    logic pushHighOnly;  // keep only bits [31:16] of the word
  } pfbStrobe_t;

  localparam logic [4:0] WIDE_MIN = 5'b11101;

  // Length detect on the first halfword of an instruction.
  function automatic logic isWide(input logic [15:0] hw);
    return hw[15:11] >= WIDE_MIN;
  endfunction

endpackage

// File: rtl/pfb_ctrl.sv
module pfb_ctrl
  import pfb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH_WORDS = 3,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0,
  localparam int HW_SLOTS = 2 * DEPTH_WORDS,
  localparam int CNT_W = $clog2(HW_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushIn,
  input  logic [ADDR_W-2:0] flushHw,
  input  logic              fetchValid,
  input  logic [CNT_W-1:0]  hwCount,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output pfbStrobe_t        strb
);

  localparam int WP_W  = ADDR_W - 2;
  localparam int SUM_W = CNT_W + 2;

  logic [WP_W-1:0]  wordPtr;
  logic             skipLow;
  logic [CNT_W-1:0] inFlight;
  logic [CNT_W-1:0] staleCnt;
  logic [CNT_W-1:0] liveCnt;
  logic [SUM_W-1:0] needSlots;
  logic             accept;

  assign liveCnt   = inFlight - staleCnt;
  // Halfword slots taken now, plus two for each live request, plus two for
  // the request under consideration.
  assign needSlots = SUM_W'(hwCount) + (SUM_W'(liveCnt) << 1) + SUM_W'(2);
  assign fetchReq  = !flushIn && (needSlots <= SUM_W'(HW_SLOTS));
  assign fetchAddr = {wordPtr, 2'b00};
  assign accept    = fetchValid && (staleCnt == '0) && !flushIn;

  always_comb begin
    strb.flush        = flushIn;
    strb.push         = accept;
    strb.pushHighOnly = skipLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordPtr  <= BOOT_ADDR[ADDR_W-1:2];
      skipLow  <= BOOT_ADDR[1];
      inFlight <= '0;
      staleCnt <= '0;
    end else if (flushIn) begin
      wordPtr  <= flushHw[ADDR_W-2:1];
      skipLow  <= flushHw[0];
      inFlight <= inFlight - CNT_W'(fetchValid);
      staleCnt <= inFlight - CNT_W'(fetchValid);
    end else begin
      if (fetchReq) wordPtr <= wordPtr + WP_W'(1);
      if (accept) skipLow <= 1'b0;
      inFlight <= inFlight + CNT_W'(fetchReq) - CNT_W'(fetchValid);
      if (fetchValid && (staleCnt != '0)) staleCnt <= staleCnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/pfb_datapath.sv
module pfb_datapath
  import pfb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH_WORDS = 3,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0,
  localparam int HW_SLOTS = 2 * DEPTH_WORDS,
  localparam int CNT_W = $clog2(HW_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfbStrobe_t        strb,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic [31:0]       fetchData,
  input  logic              instReady,
  output logic [CNT_W-1:0]  hwCount,
  output logic              instValid,
  output logic              instIs32,
  output logic [31:0]       instData,
  output logic [ADDR_W-1:0] instAddr
);

  logic [15:0]       slotQ [HW_SLOTS];
  logic [15:0]       slotN [HW_SLOTS];
  logic [ADDR_W-1:0] headAddr;
  logic              wide;
  logic              enough;
  logic              fire;
  logic [CNT_W-1:0]  popN;
  logic [CNT_W-1:0]  baseIdx;
  logic [CNT_W-1:0]  countN;

  assign wide      = isWide(slotQ[0]);
  assign enough    = wide ? (hwCount >= CNT_W'(2)) : (hwCount >= CNT_W'(1));
  assign instValid = enough && !strb.flush;
  assign instIs32  = wide;
  assign instData  = wide ? {slotQ[0], slotQ[1]} : {16'h0000, slotQ[0]};
  assign instAddr  = headAddr;

  assign fire    = instValid && instReady;
  assign popN    = fire ? (wide ? CNT_W'(2) : CNT_W'(1)) : '0;
  assign baseIdx = hwCount - popN;

  always_comb begin
    for (int i = 0; i < HW_SLOTS; i++) begin
      slotN[i] = '0;
      for (int j = 0; j < HW_SLOTS; j++) begin
        if (j == i + int'(popN)) slotN[i] = slotQ[j];
      end
      if (strb.push) begin
        if (strb.pushHighOnly) begin
          if (i == int'(baseIdx)) slotN[i] = fetchData[31:16];
        end else begin
          if (i == int'(baseIdx)) slotN[i] = fetchData[15:0];
          if (i == int'(baseIdx) + 1) slotN[i] = fetchData[31:16];
        end
      end
    end
    countN = baseIdx;
    if (strb.push) countN = baseIdx + (strb.pushHighOnly ? CNT_W'(1) : CNT_W'(2));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HW_SLOTS; i++) slotQ[i] <= '0;
      hwCount  <= '0;
      headAddr <= BOOT_ADDR;
    end else if (strb.flush) begin
      hwCount  <= '0;
      headAddr <= flushAddr;
    end else begin
      for (int i = 0; i < HW_SLOTS; i++) slotQ[i] <= slotN[i];
      hwCount <= countN;
      if (fire) headAddr <= headAddr + (wide ? ADDR_W'(4) : ADDR_W'(2));
    end
  end

endmodule

// File: rtl/hw_prefetch_buf.sv
module hw_prefetch_buf
  import pfb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH_WORDS = 3,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0,
  localparam int HW_SLOTS = 2 * DEPTH_WORDS,
  localparam int CNT_W = $clog2(HW_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchValid,
  input  logic [31:0]       fetchData,
  input  logic              flushIn,
  input  logic [ADDR_W-1:0] flushAddr,
  output logic              instValid,
  output logic              instIs32,
  output logic [31:0]       instData,
  output logic [ADDR_W-1:0] instAddr,
  input  logic              instReady
);

  pfbStrobe_t       strb;
  logic [CNT_W-1:0] hwCount;

  pfb_ctrl #(
    .ADDR_W(ADDR_W), .DEPTH_WORDS(DEPTH_WORDS), .BOOT_ADDR(BOOT_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .flushIn(flushIn),
    .flushHw(flushAddr[ADDR_W-1:1]), .fetchValid(fetchValid),
    .hwCount(hwCount), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .strb(strb)
  );

  pfb_datapath #(
    .ADDR_W(ADDR_W), .DEPTH_WORDS(DEPTH_WORDS), .BOOT_ADDR(BOOT_ADDR)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .flushAddr(flushAddr),
    .fetchData(fetchData), .instReady(instReady), .hwCount(hwCount),
    .instValid(instValid), .instIs32(instIs32), .instData(instData),
    .instAddr(instAddr)
  );

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
  parameter int ADDR_W = 32,
  parameter int DEPTH_WORDS = 3,
  localparam int HW_SLOTS = 2 * DEPTH_WORDS,
  localparam int CNT_W = $clog2(HW_SLOTS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              flushIn,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              instValid,
  input logic              instReady,
  input logic              instIs32,
  input logic [31:0]       instData,
  input logic [ADDR_W-1:0] instAddr,
  input logic [CNT_W-1:0]  hwCount
);

  p_word_align_r2: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> (fetchAddr[1:0] == 2'b00));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    hwCount <= CNT_W'(HW_SLOTS));

  p_wide_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instIs32) |-> (instData[31:27] >= 5'b11101));

  p_narrow_pad_r5: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !instIs32) |-> (instData[31:16] == 16'h0000));

  p_half_align_r7: assert property (@(posedge clk) disable iff (!rstN)
    instValid |-> !instAddr[0]);

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instReady && !flushIn) |=>
      (!instValid || instAddr == ($past(instAddr) + ($past(instIs32) ? ADDR_W'(4) : ADDR_W'(2)))));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !instReady && !flushIn) |=>
      (flushIn || (instValid && $stable(instData) && $stable(instAddr) && $stable(instIs32))));

  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |-> (!fetchReq && !instValid));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |=> !instValid);

endmodule

bind hw_prefetch_buf pfb_checker #(
  .ADDR_W(ADDR_W), .DEPTH_WORDS(DEPTH_WORDS)
) u_chk (
  .clk(clk), .rstN(rstN), .flushIn(flushIn), .fetchReq(fetchReq),
  .fetchAddr(fetchAddr), .instValid(instValid), .instReady(instReady),
  .instIs32(instIs32), .instData(instData), .instAddr(instAddr),
  .hwCount(hwCount)
);

// File: tb/hw_prefetch_buf_tb.sv
`timescale 1ns/1ps
module hw_prefetch_buf_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchReq;
  logic [31:0] fetchAddr;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchData = '0;
  logic        flushIn = 1'b0;
  logic [31:0] flushAddr = '0;
  logic        instValid;
  logic        instIs32;
  logic [31:0] instData;
  logic [31:0] instAddr;
  logic        instReady = 1'b0;

  always #5 clk = ~clk;

  hw_prefetch_buf u_dut (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid), .fetchData(fetchData), .flushIn(flushIn),
    .flushAddr(flushAddr), .instValid(instValid), .instIs32(instIs32),
    .instData(instData), .instAddr(instAddr), .instReady(instReady)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int memSeed = 0;
  int latency = 1;
  int rdyMode = 0;
  int gapMode = 0;
  int consumed = 0;
  int reqCount = 0;
  logic [31:0] pendAddr [16];
  int          pendCyc  [16];
  int pendHead = 0;
  int pendCnt = 0;
  logic [31:0] expFetch = '0;
  logic [31:0] expAddr = '0;
  logic [31:0] flushTgt = '0;
  bit firstStep = 1'b1;
  bit postFlush = 1'b0;
  bit firstAfterFlush = 1'b0;
  bit staleAtFlush = 1'b0;
  bit holdPending = 1'b0;
  logic [31:0] holdData, holdAddr;
  logic        holdIs32;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  // Halfword memory model: addresses are byte addresses, bit 0 ignored.
  function automatic logic [15:0] memHw(input logic [31:0] a);
    int k, v;
    logic [4:0]  top;
    logic [10:0] low;
    k = int'(a >> 1);
    v = (k * 5 + memSeed * 3 + (k >>> 3)) % 8;
    top = (v < 3) ? 5'(29 + v) : 5'(v);
    low = 11'(k ^ (memSeed * 37));
    return {top, low};
  endfunction

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {memHw(a + 32'd2), memHw(a)};
  endfunction

  function automatic bit readyNow();
    case (rdyMode)
      0: return 1'b1;
      1: return (cyc % 2) == 0;
      default: return (cyc % 5) >= 3;
    endcase
  endfunction

  function automatic bit busGap();
    return (gapMode != 0) && ((cyc * 3) % 7 == 0);
  endfunction

  task automatic step(input bit doFlush, input logic [31:0] tgt);
    logic [15:0] hw0;
    bit          wide;
    logic [31:0] expData;
    @(negedge clk);
    cyc++;
    if (firstStep) rstN = 1'b1;
    flushIn   = doFlush;
    flushAddr = tgt;
    fetchValid = 1'b0;
    fetchData  = '0;
    if (pendCnt > 0 && (cyc - pendCyc[pendHead]) >= latency && !busGap()) begin
      fetchValid = 1'b1;
      fetchData  = memWord(pendAddr[pendHead]);
      pendHead = (pendHead + 1) % 16;
      pendCnt--;
    end
    instReady = readyNow();
    #1;
    if (firstStep) begin
      chk(!instValid, "R1", "instValid after reset", 32'(instValid), 32'd0);
      chk(fetchReq, "R1", "fetchReq after reset", 32'(fetchReq), 32'd1);
      firstStep = 1'b0;
    end
    if (postFlush) begin
      chk(!instValid, "R9", "queue empty after flush", 32'(instValid), 32'd0);
      postFlush = 1'b0;
    end
    if (fetchReq) begin
      chk(fetchAddr == expFetch, (firstAfterFlush && reqCount == 0) ? "R9" : "R2",
          "fetchAddr", fetchAddr, expFetch);
      pendAddr[(pendHead + pendCnt) % 16] = fetchAddr;
      pendCyc[(pendHead + pendCnt) % 16]  = cyc;
      pendCnt++;
      reqCount++;
      expFetch = expFetch + 32'd4;
    end
    if (doFlush) begin
      chk(!fetchReq && !instValid, "R9", "flush cycle quiet",
          {30'd0, fetchReq, instValid}, 32'd0);
      staleAtFlush = (pendCnt > 0) || fetchValid;
      expFetch = {tgt[31:2], 2'b00};
      expAddr  = tgt;
      flushTgt = tgt;
      reqCount = 0;
      postFlush = 1'b1;
      firstAfterFlush = 1'b1;
      holdPending = 1'b0;
    end else begin
      if (holdPending) begin
        chk(instValid && instData == holdData && instAddr == holdAddr && instIs32 == holdIs32,
            "R8", "held instruction", instAddr, holdAddr);
      end
      if (instValid && instReady) begin
        hw0  = memHw(expAddr);
        wide = hw0[15:11] >= 5'b11101;
        expData = wide ? {hw0, memHw(expAddr + 32'd2)} : {16'h0000, hw0};
        chk(instIs32 == wide, "R4", "instIs32", 32'(instIs32), 32'(wide));
        if (firstAfterFlush && staleAtFlush)
          chk(instData == expData, "R10", "data after flush with stale responses", instData, expData);
        else
          chk(instData == expData, wide ? (expAddr[1] ? "R6" : "R6") : "R5", "instData",
              instData, expData);
        chk(instAddr == expAddr, (firstAfterFlush && flushTgt[1]) ? "R11" : "R7",
            "instAddr", instAddr, expAddr);
        expAddr = expAddr + (wide ? 32'd4 : 32'd2);
        consumed++;
        firstAfterFlush = 1'b0;
      end
      holdPending = instValid && !instReady;
      holdData = instData;
      holdAddr = instAddr;
      holdIs32 = instIs32;
    end
  endtask

  task automatic runInst(input int n);
    int start = consumed;
    int guard = 0;
    while ((consumed - start) < n && guard < 3000) begin
      step(1'b0, '0);
      guard++;
    end
    chk(guard < 3000, "R7", "stream progress", 32'(consumed - start), 32'(n));
  endtask

  initial begin
    // R1 reset state, then R3 capacity with the bus silent.
    latency = 100000;
    rdyMode = 2;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) step(1'b0, '0);
    chk(reqCount == 3, "R3", "requests with no responses", 32'(reqCount), 32'd3);
    latency = 1;
    rdyMode = 0;
    runInst(30);

    // Sweep: latency x decoder ready pattern x target offset x seed.
    for (int lat = 1; lat <= 3; lat++) begin
      for (int rdy = 0; rdy < 3; rdy++) begin
        for (int off = 0; off < 2; off++) begin
          for (int sd = 0; sd < 4; sd++) begin
            latency = lat;
            rdyMode = rdy;
            gapMode = sd % 2;
            memSeed = sd * 11 + lat * 3 + rdy;
            step(1'b1, 32'h0000_1000 + 32'(lat * 32'h400) + 32'(sd * 32'h40)
                       + 32'(rdy * 32'h10) + 32'(off * 2));
            runInst(12 + sd);
          end
        end
      end
    end

    // Back-to-back flushes with responses in flight.
    latency = 3;
    rdyMode = 0;
    gapMode = 0;
    memSeed = 5;
    step(1'b1, 32'h0000_8002);
    step(1'b0, '0);
    step(1'b1, 32'h0000_9006);
    step(1'b1, 32'h0000_A00A);
    runInst(25);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1900000;
    checks++;
    errors++;
    $display("FAIL watchdog: got %0d expected 0 (cycle %0d)", cyc, cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule